// File: doc/BRIEF.md
# Approximate Reciprocal Square Root Unit

This block takes one IEEE-754 single-precision value and returns an estimate of one over its square root. A small seed table is read first. One Newton step then refines the seed. The 32-bit estimate goes into the low lane of a wide destination vector. A mode bit chooses how the lanes above it are filled:

- In legacy mode they keep the old destination contents.
- In three-operand mode they take bits 127:32 of a second source vector, and everything above bit 127 is cleared.

The unit is a three-stage pipeline with valid/ready handshakes on both sides. Special inputs (zero, subnormal, negative, infinite, NaN) skip the arithmetic path. They produce fixed encodings chosen in the first stage. There is no rounding-control input. The result depends only on the source bits. No exception flags are produced.

A use is one transfer in and one transfer out. The destination width is a parameter of at least 128 bits. Results leave in the order the inputs were accepted.

Top module: `rsqrt_unit`

## Requirements
- R1: For a positive normal input x (sign 0, biased exponent 1..254), the result has sign 0, a biased exponent in 1..254, and |result·sqrt(x) − 1| ≤ 1.5·2^-12.
- R2: An input of +0 (0x00000000) gives 0x7F800000, and −0 (0x80000000) gives 0xFF800000.
- R3: A subnormal input (biased exponent 0, fraction nonzero) gives the infinity of its own sign: 0x7F800000 or 0xFF800000.
- R4: A negative input that is not a zero, a subnormal or a NaN, including −infinity, gives 0xFFC00000.
- R5: A NaN input (exponent 255, fraction nonzero) gives the input with fraction bit 22 forced to 1, so sign and payload are kept. A quiet NaN (bit 22 already 1) is returned bit-exact.
- R6: +infinity (0x7F800000) gives +0 (0x00000000).
- R7: With in_mode = 0, out_data[DW-1:32] equals in_dest[DW-1:32] of the same transfer.
- R8: With in_mode = 1, out_data[127:32] equals in_vsrc[127:32] and out_data[DW-1:128] is zero.
- R9: out_data[31:0] depends only on in_src. It is the same for both modes and for any vector inputs.
- R10: With out_ready held high, a result appears on out_valid three clock edges after its input is accepted, and results keep the input order.
- R11: While out_valid is high and out_ready is low, out_valid stays high, out_data holds, and in_ready is low.
- R12: During and right after reset, out_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input transfer request |
| in_ready | output | 1 | Unit can accept an input this cycle |
| in_src | input | 32 | Single-precision operand |
| in_dest | input | DW | Previous destination contents (legacy mode) |
| in_vsrc | input | 128 | Second source vector (three-operand mode) |
| in_mode | input | 1 | 0 = legacy merge, 1 = three-operand merge |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer accepts the result |
| out_data | output | DW | Merged destination vector |

## Verification
On every cycle the assertions check the following:
- an output held under back-pressure stays stable;
- in three-operand mode the lanes above bit 127 leave as zero;
- a NaN carries its quiet bit and all-ones exponent out of classification;
- each table seed lies in [0.5, 1);
- each arithmetic-path result is positive with a finite, nonzero exponent.

Other properties show up only in the bench scenarios:
- the relative-error bound, checked against a real-valued model over random and boundary inputs;
- the exact encodings for each special class;
- the three-edge latency;
- that the low lane is the same in both merge modes.

// File: rtl/rsq_pkg.sv
// Package: shared constants, kinds and the seed-table generator for the
// reciprocal square root unit. Fixed-point values use FB fraction bits.
package rsq_pkg;

    localparam int FB     = 23;              // fraction bits of internal fixed point
    localparam int IB     = 6;               // mantissa bits used to index the seed table
    localparam int SEED_N = 1 << (IB + 1);   // entries: exponent parity x mantissa slices
    localparam int YW     = FB + 1;          // seed / estimate width, value below 2
    localparam int MW     = FB + 2;          // scaled mantissa width, value in [1,4)
    localparam int DWD    = FB + 3;          // Newton residual width
    localparam logic [31:0] INDEF = 32'hFFC0_0000;

    typedef enum logic [2:0] {
        K_NORM,   // positive normal, goes through the arithmetic path
        K_ZERO,   // zero or subnormal: signed infinity
        K_NAN,    // any NaN: quieted copy
        K_NEG,    // negative non-zero: indefinite
        K_PINF    // positive infinity: +0
    } kind_t;

    // Integer square root, bit by bit; argument below 2^62.
    function automatic logic [63:0] isqrt64(input logic [63:0] v);
        logic [63:0] res;
        logic [63:0] trial;
        res = '0;
        for (int i = 31; i >= 0; i--) begin
            trial = res | (64'd1 << i);
            if (trial * trial <= v) res = trial;
        end
        return res;
    endfunction

    // Seed for one entry: 1/sqrt of the slice midpoint, FB fraction bits.
    // Index MSB = exponent LSB (1: mantissa in [1,2), 0: mantissa doubled).
    function automatic logic [YW-1:0] seed_entry(input int idx);
        logic [63:0] n;
        logic [63:0] q;
        int          j;
        j = idx % (1 << IB);
        n = 64'(2 * j + 1 + (1 << (IB + 1)));
        if (((idx >> IB) & 1) == 0) n = n * 2;
        q = (64'd1 << (2 * FB + IB + 1)) / n;
        return YW'(isqrt64(q));
    endfunction

    // Whole table packed into one vector, entry k at bits [k*YW +: YW].
    function automatic logic [SEED_N*YW-1:0] build_rom();
        logic [SEED_N*YW-1:0] r;
        r = '0;
        for (int k = 0; k < SEED_N; k++) r[k*YW +: YW] = seed_entry(k);
        return r;
    endfunction

endpackage

// File: rtl/rsq_classify.sv
// Module: sorts the operand into a kind, forms the fixed result for the
// special kinds, and prepares the scaled mantissa, seed index and exponent
// base for the arithmetic path. Purely combinational.
// Assumes IEEE-754 single-precision encoding of x.
module rsq_classify
    import rsq_pkg::*;
(
    input  logic [31:0]   x,
    output kind_t         kind,
    output logic [31:0]   spec,
    output logic [7:0]    ebase,
    output logic [MW-1:0] mfix,
    output logic [IB:0]   sidx
);
    logic         sgn;
    logic [7:0]   ex;
    logic [FB-1:0] fr;
    logic [8:0]   ediff;

    assign sgn = x[31];
    assign ex  = x[30:23];
    assign fr  = x[FB-1:0];

    // Kind selection in priority order: NaN, zero/subnormal, negative, +inf.
    always_comb begin
        kind = K_NORM;
        spec = '0;
        if (ex == 8'hFF && fr != '0) begin
            kind = K_NAN;
            spec = {sgn, 8'hFF, 1'b1, fr[FB-2:0]};
        end else if (ex == 8'h00) begin
            kind = K_ZERO;
            spec = {sgn, 8'hFF, {FB{1'b0}}};
        end else if (sgn) begin
            kind = K_NEG;
            spec = INDEF;
        end else if (ex == 8'hFF) begin
            kind = K_PINF;
            spec = '0;
        end
    end

    // Exponent base: result field for an estimate in [0.5,1) before normalising.
    assign ediff = 9'd380 - {1'b0, ex};
    assign ebase = ediff[8:1];

    // Scaled mantissa: odd exponent keeps 1.f, even exponent doubles it.
    assign mfix = ex[0] ? {2'b01, fr} : {1'b1, fr, 1'b0};

    // Seed index: exponent parity and the top mantissa bits.
    assign sidx = {ex[0], fr[FB-1 -: IB]};

    logic unused_bit;
    assign unused_bit = ediff[0];
endmodule

// File: rtl/rsq_seed.sv
// Module: seed lookup. The table is built at elaboration from integer
// square roots, so no constants are written out by hand.
// Every entry lies in [0.5,1) with FB fraction bits.
module rsq_seed
    import rsq_pkg::*;
(
    input  logic [IB:0]   idx,
    output logic [YW-1:0] y0
);
    localparam logic [SEED_N*YW-1:0] ROM = build_rom();

    // Table read.
    assign y0 = ROM[idx*YW +: YW];
endmodule

// File: rtl/rsq_residual.sv
// Module: first half of the Newton step, d = 3 - m*y0^2.
// Assumes y0 near 1/sqrt(m), so m*y0^2 is near 1 and d near 2.
module rsq_residual
    import rsq_pkg::*;
(
    input  logic [YW-1:0]  y0,
    input  logic [MW-1:0]  m,
    output logic [DWD-1:0] d
);
    localparam logic [DWD-1:0] THREE = DWD'(3) << FB;

    logic [2*YW-1:0]  sq;
    logic [YW-1:0]    sq_t;
    logic [MW+YW-1:0] prod;
    logic [DWD-1:0]   u;

    // Square of the seed, truncated back to FB fraction bits.
    assign sq   = {{YW{1'b0}}, y0} * {{YW{1'b0}}, y0};
    assign sq_t = sq[FB +: YW];

    // Scaled by the mantissa, then subtracted from three.
    assign prod = {{YW{1'b0}}, m} * {{MW{1'b0}}, sq_t};
    assign u    = prod[FB +: DWD];
    assign d    = THREE - u;

    logic unused_bits;
    assign unused_bits = ^{sq[FB-1:0], sq[2*YW-1], prod[FB-1:0]};
endmodule

// File: rtl/rsq_finish.sv
// Module: second half of the Newton step and packing. The product y0*d
// equals twice the refined estimate. It is normalised by one of three
// shifts, because the estimate may fall just below 0.5 or reach 1.0.
module rsq_finish
    import rsq_pkg::*;
(
    input  logic [YW-1:0]  y0,
    input  logic [DWD-1:0] d,
    input  logic [7:0]     ebase,
    output logic [31:0]    word
);
    logic [YW+DWD-1:0] p;
    logic [FB+1:0]     w;
    logic [7:0]        ex;
    logic [FB-1:0]     man;

    // Twice the refined estimate, FB fraction bits.
    assign p = {{DWD{1'b0}}, y0} * {{YW{1'b0}}, d};
    assign w = p[FB +: FB+2];

    // Normalise: at or above 2, in [1,2), or just below 1.
    always_comb begin
        if (w[FB+1]) begin
            ex  = ebase + 8'd1;
            man = w[FB:1];
        end else if (w[FB]) begin
            ex  = ebase;
            man = w[FB-1:0];
        end else begin
            ex  = ebase - 8'd1;
            man = {w[FB-2:0], 1'b0};
        end
    end

    assign word = {1'b0, ex, man};

    logic unused_bits;
    assign unused_bits = ^{p[FB-1:0], p[YW+DWD-1:2*FB+2]};
endmodule

// File: rtl/rsqrt_unit.sv
// Module: top of the approximate reciprocal square root unit.
// Stage 1 classifies, reads the seed and selects the upper lanes.
// Stage 2 forms the Newton residual. Stage 3 finishes the estimate
// or takes the special result.
// The whole pipe advances together whenever the last stage is empty or
// drained; bubbles are not squeezed out. Assumes DW >= 128.
module rsqrt_unit
    import rsq_pkg::*;
#(
    parameter int DW = 256
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [31:0]   in_src,
    input  logic [DW-1:0] in_dest,
    input  logic [127:0]  in_vsrc,
    input  logic          in_mode,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [DW-1:0] out_data
);
    localparam int UW = DW - 32;

    logic en;
    logic s1_v, s2_v, s3_v;

    kind_t         c_kind;
    logic [31:0]   c_spec;
    logic [7:0]    c_ebase;
    logic [MW-1:0] c_m;
    logic [IB:0]   c_idx;
    logic [YW-1:0] c_y0;
    logic [UW-1:0] c_upper;

    kind_t          s1_kind, s2_kind;
    logic [31:0]    s1_spec, s2_spec;
    logic [7:0]     s1_ebase, s2_ebase;
    logic [MW-1:0]  s1_m;
    logic [YW-1:0]  s1_y0, s2_y0;
    logic [UW-1:0]  s1_upper, s2_upper, s3_upper;
    logic           s1_mode, s2_mode, s3_mode;
    logic [DWD-1:0] r_d, s2_d;
    logic [31:0]    f_word;
    logic [31:0]    s3_res;

    // Pipe advance: last stage empty or being taken.
    assign en       = !s3_v || out_ready;
    assign in_ready = en;

    rsq_classify u_cls (
        .x     (in_src),
        .kind  (c_kind),
        .spec  (c_spec),
        .ebase (c_ebase),
        .mfix  (c_m),
        .sidx  (c_idx)
    );

    rsq_seed u_seed (
        .idx (c_idx),
        .y0  (c_y0)
    );

    // Upper-lane selection for the two merge modes.
    always_comb begin
        if (in_mode) begin
            c_upper       = '0;
            c_upper[95:0] = in_vsrc[127:32];
        end else begin
            c_upper = in_dest[DW-1:32];
        end
    end

    // Valid bits of the three stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_v <= 1'b0;
            s2_v <= 1'b0;
            s3_v <= 1'b0;
        end else if (en) begin
            s1_v <= in_valid;
            s2_v <= s1_v;
            s3_v <= s2_v;
        end
    end

    // Stage 1 data capture.
    always_ff @(posedge clk) begin
        if (en) begin
            s1_kind  <= c_kind;
            s1_spec  <= c_spec;
            s1_ebase <= c_ebase;
            s1_m     <= c_m;
            s1_y0    <= c_y0;
            s1_upper <= c_upper;
            s1_mode  <= in_mode;
        end
    end

    rsq_residual u_res (
        .y0 (s1_y0),
        .m  (s1_m),
        .d  (r_d)
    );

    // Stage 2 data capture.
    always_ff @(posedge clk) begin
        if (en) begin
            s2_kind  <= s1_kind;
            s2_spec  <= s1_spec;
            s2_ebase <= s1_ebase;
            s2_y0    <= s1_y0;
            s2_d     <= r_d;
            s2_upper <= s1_upper;
            s2_mode  <= s1_mode;
        end
    end

    rsq_finish u_fin (
        .y0    (s2_y0),
        .d     (s2_d),
        .ebase (s2_ebase),
        .word  (f_word)
    );

    // Stage 3 capture: arithmetic or special result.
    always_ff @(posedge clk) begin
        if (en) begin
            s3_res   <= (s2_kind == K_NORM) ? f_word : s2_spec;
            s3_upper <= s2_upper;
            s3_mode  <= s2_mode;
        end
    end

    assign out_valid = s3_v;
    assign out_data  = {s3_upper, s3_res};

    logic unused_bits;
    assign unused_bits = ^{in_vsrc[31:0], in_dest[31:0]};

    // R11: a result refused by the consumer stays valid and unchanged.
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R5: a NaN leaves classification with the quiet bit and exponent all ones.
    a_r5_nan_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_v && s1_kind == K_NAN) |-> (s1_spec[30:22] == 9'h1FF));

    // R1: the seed of a normal operand lies in [0.5,1).
    a_r1_seed_range: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_v && s1_kind == K_NORM) |-> (s1_y0[YW-1:YW-2] == 2'b01));

    // R1: the arithmetic path gives a positive, finite, nonzero exponent.
    a_r1_positive: assert property (@(posedge clk) disable iff (!rst_n)
        (s3_v && $past(s2_kind) == K_NORM && $past(en))
        |-> (!out_data[31] && out_data[30:23] != 8'h00 && out_data[30:23] != 8'hFF));

    // R8: three-operand mode clears the lanes above bit 127.
    generate
        if (DW > 128) begin : g_wide
            a_r8_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
                (out_valid && s3_mode) |-> (out_data[DW-1:128] == '0));
        end
    endgenerate
endmodule

// File: tb/sim_rsqrt_unit.sv
`timescale 1ns/1ps
module sim_rsqrt_unit;
    localparam int DW    = 256;
    localparam int NRAND = 3000;
    localparam int WD    = 150000;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          in_valid;
    logic          in_ready;
    logic [31:0]   in_src;
    logic [DW-1:0] in_dest;
    logic [127:0]  in_vsrc;
    logic          in_mode;
    logic          out_valid;
    logic          out_ready;
    logic [DW-1:0] out_data;

    int n_checks = 0;
    int n_err    = 0;

    logic [31:0]   q_src  [0:7];
    logic          q_mode [0:7];
    logic [DW-1:0] q_dest [0:7];
    logic [127:0]  q_vsrc [0:7];

    always #2.5 clk = ~clk;

    rsqrt_unit #(.DW(DW)) u0 (
        .clk, .rst_n, .in_valid, .in_ready, .in_src, .in_dest, .in_vsrc,
        .in_mode, .out_valid, .out_ready, .out_data
    );

    task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] expv);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    function automatic real pow2(input int k);
        real r = 1.0;
        if (k >= 0) for (int i = 0; i < k; i++) r = r * 2.0;
        else for (int i = 0; i < -k; i++) r = r / 2.0;
        return r;
    endfunction

    function automatic real val_of(input logic [31:0] b);
        real m = 1.0 + real'(b[22:0]) / 8388608.0;
        return m * pow2(int'(b[30:23]) - 127);
    endfunction

    // Expected result for the special classes; is_spec=0 means normal path.
    function automatic logic [31:0] spec_exp(input logic [31:0] s, output bit is_spec,
                                             output string tag);
        is_spec = 1'b1;
        tag = "R1";
        if (s[30:23] == 8'hFF && s[22:0] != 0) begin
            tag = "R5"; return s | 32'h0040_0000;
        end
        if (s[30:0] == 0) begin
            tag = "R2"; return {s[31], 31'h7F80_0000};
        end
        if (s[30:23] == 0) begin
            tag = "R3"; return {s[31], 31'h7F80_0000};
        end
        if (s[31]) begin
            tag = "R4"; return 32'hFFC0_0000;
        end
        if (s[30:23] == 8'hFF) begin
            tag = "R6"; return 32'h0;
        end
        is_spec = 1'b0;
        return 32'h0;
    endfunction

    task automatic check_out(input logic [31:0] s, input logic m,
                             input logic [DW-1:0] dst, input logic [127:0] vs,
                             input logic [DW-1:0] got);
        bit          sp;
        string       tag;
        logic [31:0] e32;
        logic [DW-1:0] ev;
        real         ref_v, g, rel;
        e32 = spec_exp(s, sp, tag);
        if (sp) begin
            chk(got[31:0] == e32, tag, DW'(got[31:0]), DW'(e32));
        end else begin
            ref_v = 1.0 / $sqrt(val_of(s));
            g = val_of(got[31:0]);
            rel = (g - ref_v) / ref_v;
            if (rel < 0.0) rel = -rel;
            n_checks++;
            if (got[31] || got[30:23] == 0 || got[30:23] == 8'hFF ||
                rel > 1.5 / 4096.0) begin
                n_err++;
                $display("FAIL R1 src=%h actual=%h (%g) expected=%g", s, got[31:0], g, ref_v);
            end
        end
        ev = '0;
        if (m) begin
            ev[127:32] = vs[127:32];
            chk(got[DW-1:32] == ev[DW-1:32], "R8", got, ev);
        end else begin
            ev[DW-1:32] = dst[DW-1:32];
            chk(got[DW-1:32] == ev[DW-1:32], "R7", got, ev);
        end
    endtask

    function automatic logic [DW-1:0] rvec();
        logic [DW-1:0] v;
        for (int i = 0; i < DW / 32; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    function automatic logic [31:0] rsrc();
        logic [31:0] f = $urandom;
        int c = $urandom % 16;
        case (c)
            0: return {f[31], 31'h0};
            1: return {f[31], 8'h00, f[22:1], 1'b1};
            2: return {1'b1, 8'(1 + ($urandom % 254)), f[22:0]};
            3: return 32'hFF80_0000;
            4: return 32'h7F80_0000;
            5: return {f[31], 8'hFF, 1'b0, f[21:1], 1'b1};
            6: return {f[31], 8'hFF, 1'b1, f[21:0]};
            default: return {1'b0, 8'(1 + ($urandom % 254)), f[22:0]};
        endcase
    endfunction

    function automatic logic [31:0] dir_val(input int i);
        case (i)
            0: return 32'h3F80_0000;  1: return 32'h4080_0000;
            2: return 32'h4000_0000;  3: return 32'h3FFF_FFFF;
            4: return 32'h407F_FFFF;  5: return 32'h0080_0000;
            6: return 32'h7F7F_FFFF;  7: return 32'h3F00_0000;
            8: return 32'h0000_0000;  9: return 32'h8000_0000;
            10: return 32'h0000_0001; 11: return 32'h807F_FFFF;
            12: return 32'hBF80_0000; 13: return 32'hFF80_0000;
            14: return 32'h7F80_0000; 15: return 32'h7F80_0001;
            16: return 32'hFFA0_0000; 17: return 32'h7FC1_2345;
            default: return 32'h4049_0FDB;
        endcase
    endfunction

    // One isolated transfer with out_ready high; returns data and latency.
    task automatic run_one(input logic [31:0] s, input logic m, input logic [DW-1:0] dst,
                           input logic [127:0] vs, output logic [DW-1:0] got,
                           output int lat);
        @(negedge clk);
        in_src = s; in_mode = m; in_dest = dst; in_vsrc = vs;
        in_valid = 1'b1; out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        lat = 1;
        while (!out_valid && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        got = out_data;
        check_out(s, m, dst, vs, got);
    endtask

    initial begin
        repeat (WD) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("  Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        logic [DW-1:0] g0, g1, held;
        int lat, wr, rd, sent;
        bit stable_ok;
        void'($urandom(32'h5EED_1234));
        rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
        in_src = '0; in_dest = '0; in_vsrc = '0; in_mode = 1'b0;
        repeat (3) @(negedge clk);
        // R12: reset state
        chk(out_valid == 1'b0, "R12", DW'(out_valid), DW'(0));
        chk(in_ready == 1'b1, "R12", DW'(in_ready), DW'(1));
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R12", DW'(out_valid), DW'(0));

        // Directed corner inputs (R1..R6) and latency R10
        for (int i = 0; i < 18; i++) begin
            run_one(dir_val(i), 1'(i % 2), rvec(), rvec()[127:0], g0, lat);
            chk(lat == 3, "R10", DW'(lat), DW'(3));
        end

        // R9: low lane independent of mode and vectors
        run_one(32'h4049_0FDB, 1'b0, rvec(), rvec()[127:0], g0, lat);
        run_one(32'h4049_0FDB, 1'b1, rvec(), rvec()[127:0], g1, lat);
        chk(g0[31:0] == g1[31:0], "R9", DW'(g1[31:0]), DW'(g0[31:0]));

        // R11: stall holds the result and blocks the input
        @(negedge clk);
        out_ready = 1'b0; in_valid = 1'b1;
        in_src = 32'h4110_0000; in_mode = 1'b0; in_dest = rvec(); in_vsrc = '0;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        held = out_data;
        chk(out_valid == 1'b1, "R11", DW'(out_valid), DW'(1));
        stable_ok = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            #1;
            if (!out_valid || out_data != held || in_ready) stable_ok = 1'b0;
        end
        chk(stable_ok, "R11", out_data, held);
        in_valid = 1'b0;
        check_out(32'h4110_0000, 1'b0, in_dest, in_vsrc, held);
        out_ready = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R11", DW'(out_valid), DW'(0));

        // Random traffic with random back-pressure: R1..R8, R10 ordering
        wr = 0; rd = 0; sent = 0;
        while (sent < NRAND || rd < wr) begin
            @(negedge clk);
            out_ready = ($urandom % 4) != 0;
            if (sent < NRAND && ($urandom % 4) != 0) begin
                in_valid = 1'b1;
                in_src = rsrc(); in_mode = 1'($urandom);
                in_dest = rvec(); in_vsrc = rvec()[127:0];
            end else begin
                in_valid = 1'b0;
            end
            #1;
            if (out_valid && out_ready) begin
                check_out(q_src[rd % 8], q_mode[rd % 8], q_dest[rd % 8],
                          q_vsrc[rd % 8], out_data);
                rd++;
            end
            if (in_valid && in_ready) begin
                q_src[wr % 8] = in_src; q_mode[wr % 8] = in_mode;
                q_dest[wr % 8] = in_dest; q_vsrc[wr % 8] = in_vsrc;
                wr++; sent++;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid == 1'b0, "R10", DW'(out_valid), DW'(0));
        $display("  Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule